// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a combinational 16-bit adder. It takes two operands and a carry-in, and it returns a 16-bit sum and a carry-out. The operand width is divided into four groups of four bits.

Inside each group, every carry is formed from the per-bit generate and propagate terms and the carry entering the group. Each of these carries is a flat sum of products, so no bit waits on the carry of the bit below it.

Each group also reports a group generate and a group propagate. A second lookahead stage, which uses the same flat expansion, turns those pairs and the external carry-in into the carry entering each group and the final carry-out. A surrounding datapath feeds the operands and reads the result within the same cycle, because there is no register inside the block.

Top module: `cla16_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals the 17-bit value a + b + cin.
- R2: With both operands zero, cin = 1 gives sum = 16'h0001 and cout = 0, and cin = 0 gives sum = 0 and cout = 0.
- R3: a = 16'hFFFF with b = 0 and cin = 1 gives sum = 0 and cout = 1. The carry-in travels through all sixteen propagating bits.
- R4: Whenever a ^ b is all ones, cout equals cin, and sum is 16'hFFFF for cin = 0 or 16'h0000 for cin = 1.
- R5: The carry entering group k (bits 4k to 4k+3) equals the carry out of the addition of the low 4k bits of a and b plus cin. The carry-out is the case k = 4.
- R6: A group in which every bit has a ^ b = 1 passes the carry entering it to the next group unchanged. For example, 16'h00F8 + 16'h0008 = 16'h0100.
- R7: A group that generates a carry internally delivers it to the next group even when the carry entering it is 0. For example, 16'h0008 + 16'h0008 = 16'h0010, and 16'h8000 + 16'h8000 gives sum 0 with cout = 1.
- R8: The outputs depend only on the present inputs and follow a change of the inputs within the same cycle, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The bench drives four kinds of operand pattern:
- Chains of propagating groups with a carry born at their low end. A broken group-propagate product would drop the carry there, and the sum would come out short by a power of sixteen.
- Pure-generate groups with no incoming carry. A group generate that missed one of its product terms would lose the carry at the group edge.
- The all-ones-plus-carry-in case and the a ^ b all ones pattern. These expose any carry expansion that omits the carry-in term, which would leave cout stuck at 0.
- Random operands, biased toward long propagate runs. A wrong term deep in the second-level expansion would show up only when three or four groups propagate together.

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 4
) (
  input  logic [GROUPS*GROUP_W-1:0] a,
  input  logic [GROUPS*GROUP_W-1:0] b,
  input  logic                      cin,
  output logic [GROUPS*GROUP_W-1:0] sum,
  output logic                      cout
);
  localparam int W = GROUPS * GROUP_W;

  logic [W-1:0]    bit_g, bit_p, cy;
  logic [GROUPS-1:0] grp_g, grp_p;
  logic [GROUPS:0]   grp_c;

  assign bit_g = a & b;
  assign bit_p = a | b;

  for (genvar q = 0; q < GROUPS; q++) begin : g_grp
    logic [GROUP_W-1:0] gv, pv, cv;
    logic               gsum, run_p;

    assign gv = bit_g[q*GROUP_W +: GROUP_W];
    assign pv = bit_p[q*GROUP_W +: GROUP_W];

    always_comb begin
      cv    = '0;
      cv[0] = grp_c[q];
      for (int j = 0; j < GROUP_W - 1; j++) begin
        cv[j+1] = 1'b0;
        run_p   = 1'b1;
        for (int k = j; k >= 0; k--) begin
          cv[j+1] = cv[j+1] | (run_p & gv[k]);
          run_p   = run_p & pv[k];
        end
        cv[j+1] = cv[j+1] | (run_p & grp_c[q]);
      end
    end

    always_comb begin
      gsum = 1'b0;
      for (int k = GROUP_W - 1; k >= 0; k--) begin
        logic prod;
        prod = gv[k];
        for (int m = k + 1; m < GROUP_W; m++) prod = prod & pv[m];
        gsum = gsum | prod;
      end
    end

    assign grp_g[q] = gsum;
    assign grp_p[q] = &pv;
    assign cy[q*GROUP_W +: GROUP_W] = cv;
  end

  always_comb begin
    logic run;
    grp_c    = '0;
    grp_c[0] = cin;
    for (int j = 0; j < GROUPS; j++) begin
      grp_c[j+1] = 1'b0;
      run        = 1'b1;
      for (int k = j; k >= 0; k--) begin
        grp_c[j+1] = grp_c[j+1] | (run & grp_g[k]);
        run        = run & grp_p[k];
      end
      grp_c[j+1] = grp_c[j+1] | (run & cin);
    end
  end

  assign sum  = a ^ b ^ cy;
  assign cout = grp_c[GROUPS];
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 4
) (
  input logic [GROUPS*GROUP_W-1:0] a,
  input logic [GROUPS*GROUP_W-1:0] b,
  input logic                      cin,
  input logic [GROUPS*GROUP_W-1:0] sum,
  input logic                      cout,
  input logic [GROUPS:0]           grp_c
);
  localparam int W = GROUPS * GROUP_W;

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      assert_total_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("R1 total mismatch");
      if ((a ^ b) == {W{1'b1}}) begin
        assert_allprop_R4: assert (cout == cin && sum == {W{~cin}})
          else $error("R4 full propagate mismatch");
      end
    end
  end

  always_comb begin
    logic [W:0] part;
    logic [W-1:0] m;
    if (!$isunknown({a, b, cin})) begin
      for (int q = 1; q <= GROUPS; q++) begin
        m    = {W{1'b1}} >> (W - q*GROUP_W);
        part = {1'b0, a & m} + {1'b0, b & m} + {{W{1'b0}}, cin};
        assert_grp_carry_R5: assert (grp_c[q] == part[q*GROUP_W])
          else $error("R5 group carry %0d mismatch", q);
      end
      for (int q = 0; q < GROUPS; q++) begin
        if (((a ^ b) >> (q*GROUP_W) & {{(W-GROUP_W){1'b0}}, {GROUP_W{1'b1}}})
            == {{(W-GROUP_W){1'b0}}, {GROUP_W{1'b1}}}) begin
          assert_grp_pass_R6: assert (grp_c[q+1] == grp_c[q])
            else $error("R6 propagate group %0d altered carry", q);
        end
      end
    end
  end
endmodule

bind cla16_adder cla16_adder_chk #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grp_c(grp_c)
);

// File: tb/tb_cla16_adder.sv
module tb_cla16_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cla16_adder dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic apply(input logic [W-1:0] x, y, input logic c, input string tag);
    logic [W:0] exp;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    exp = ref_add(x, y, c);
    n_chk++;
    if ({cout, sum} !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%b got {cout,sum}=%h expected %h",
               tag, x, y, c, {cout, sum}, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    logic [W-1:0] x, y, msk;
    void'($urandom(32'h1a2b3c4d));
    @(negedge clk);
    n_chk++;
    if ({cout, sum} !== 17'h0) begin
      n_fail++;
      $display("FAIL R2 idle: got %h expected %h", {cout, sum}, 17'h0);
    end
    apply(16'h0000, 16'h0000, 1'b1, "R2 cin only");
    apply(16'h0000, 16'h0000, 1'b0, "R2 zeros");
    apply(16'hFFFF, 16'h0000, 1'b1, "R3 all ones plus cin");
    apply(16'hFFFF, 16'h0001, 1'b0, "R3 all ones plus one");
    apply(16'hA5C3, 16'h5A3C, 1'b0, "R4 a^b ones cin0");
    apply(16'hA5C3, 16'h5A3C, 1'b1, "R4 a^b ones cin1");
    apply(16'h00F8, 16'h0008, 1'b0, "R6 propagate group 1");
    apply(16'h0FF0, 16'h0000, 1'b0, "R5 no carry");
    apply(16'h0FF8, 16'h0008, 1'b0, "R6 two propagate groups");
    apply(16'hFFF0, 16'h0010, 1'b0, "R5 carry into top group");
    apply(16'h0008, 16'h0008, 1'b0, "R7 group generate");
    apply(16'h8000, 16'h8000, 1'b0, "R7 top group generate");
    apply(16'h0880, 16'h0880, 1'b1, "R7 mixed generates");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R1 max operands");
    x = 16'h1234; y = 16'h4321;
    @(posedge clk); a = x; b = y; cin = 1'b0;
    #1;
    n_chk++;
    if ({cout, sum} !== ref_add(x, y, 1'b0)) begin
      n_fail++;
      $display("FAIL R8 same-cycle: got %h expected %h", {cout, sum}, ref_add(x, y, 1'b0));
    end
    for (int i = 0; i < 1500; i++) begin
      x = W'($urandom);
      y = W'($urandom);
      apply(x, y, 1'($urandom), "R1 random");
    end
    for (int i = 0; i < 1500; i++) begin
      x   = W'($urandom);
      msk = W'($urandom) & W'($urandom) & W'($urandom);
      y   = ~x ^ msk;
      apply(x, y, 1'($urandom), "R5 biased propagate");
    end
    done = 1'b1;
    finish_run();
  end
endmodule